// File: doc/BRIEF.md
# Countdown Watchdog with Selectable Unit and Reset Shape

The block is a countdown watchdog held in a small register bank. Software writes an 8-bit reload count; while the timer is enabled, that count falls by one for every elapsed time unit, either one second or one minute. A 1 kHz tick input is the time base. Each write of the count register restarts the countdown and serves as the keepalive.

If the count falls to zero, the block pulls an active-low reset output low and sets a sticky timeout status bit. The reset can be a held level that lasts until software disables the timer. It can also be a pulse, with one of four widths measured in milliseconds. The reset reaches the output only when two bits of a separate output register both permit it.

Register map, on a 2-bit address: 0 is configuration, 1 is the reload count (reads return the live count), 2 is the output control, and 3 reads as zero. Configuration bits: bit 6 is the timeout status, bit 5 the timer enable, bit 4 selects pulse (1) or level (0), bit 3 selects minutes (1) or seconds (0), and bits 1:0 are the pulse-width code. Bits 7 and 2 are spare storage. In the output control register, bit 7 is the output enable and bit 0 the device enable. The other bits are spare storage.

Top module: `wd_timer`

## Requirements
- R1: After reset, wdt_rst_n is high and addresses 0, 1 and 2 all read 0x00; read data appears one clock after the address is presented.
- R2: In seconds mode (config bit 3 = 0), after the count register is written with N > 0 and while the timer is enabled, wdt_rst_n goes low exactly N*TICKS_PER_SEC*TICK_CYCLES+1 cycles after the write edge, with tick_ms high every cycle.
- R3: In minutes mode (config bit 3 = 1), the delay is N*TICKS_PER_SEC*SECS_PER_MIN+1 cycles under the same conditions.
- R4: A read of address 1 returns the live count. Rewriting the count reloads it and restarts the sub-unit prescaler, so the full delay starts again from that write.
- R5: A count of zero never decrements and never raises a timeout. After a timeout, no further timeout occurs until the next reload.
- R6: Clearing the enable bit (config bit 5) freezes the count, clears the prescaler and fires no reset. Setting it again resumes from the held count with a fresh unit.
- R7: In level mode (config bit 4 = 0), wdt_rst_n stays low after a timeout until the enable bit is cleared, and goes high two cycles after that write.
- R8: In pulse mode (config bit 4 = 1), wdt_rst_n is low for exactly PW_CODEn_MS consecutive tick_ms pulses, where n is the code in config bits 1:0 (0..3).
- R9: The timeout status (config bit 6) is set by a timeout and stays set. A config write with bit 6 = 1 clears it; a config write with bit 6 = 0 leaves it unchanged.
- R10: wdt_rst_n can be low only while output-control bit 7 and bit 0 are both 1. Status and internal reset state are unaffected by these bits, and changing them alters the output one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| tick_ms | input | 1 | 1 kHz time-base pulse, one cycle wide |
| wdt_rst_n | output | 1 | Active-low watchdog reset, registered |

## Verification
The bench builds the block with TICKS_PER_SEC = 4 and SECS_PER_MIN = 3, so a second spans four ticks and a minute twelve. It also uses pulse widths of 1, 2, 3 and 6 ticks. With these values, exact-cycle delays for both units, all four pulse codes, and freeze-and-resume across a partial unit each complete in tens of cycles rather than millions. Holding tick_ms high makes each expected delay a closed-form cycle count.

// File: rtl/wd_timer_pkg.sv
package wd_timer_pkg;

  typedef enum logic [1:0] {
    ADDR_CFG = 2'd0,
    ADDR_CNT = 2'd1,
    ADDR_OUT = 2'd2,
    ADDR_RSV = 2'd3
  } wd_addr_e;

  localparam int CFG_STS_BIT   = 6;
  localparam int CFG_EN_BIT    = 5;
  localparam int CFG_PULSE_BIT = 4;
  localparam int CFG_MIN_BIT   = 3;
  localparam int OUT_OE_BIT    = 7;
  localparam int OUT_DEV_BIT   = 0;

  typedef struct packed {
    logic       spare_hi;
    logic       sts;
    logic       en;
    logic       pulse;
    logic       minutes;
    logic       spare_lo;
    logic [1:0] width;
  } wd_cfg_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wd_unit_tick.sv
module wd_unit_tick #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SECS_PER_MIN  = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic tick_ms,
  input  logic minutes,
  output logic unit_tick
);
  localparam int MSW = $clog2(TICKS_PER_SEC + 1);
  localparam int SSW = $clog2(SECS_PER_MIN + 1);

  logic [MSW-1:0] ms_cnt;
  logic [SSW-1:0] sec_cnt;
  logic           sec_tick;
  logic           min_tick;

  assign sec_tick  = run && tick_ms && (ms_cnt == MSW'(TICKS_PER_SEC - 1));
  assign min_tick  = sec_tick && (sec_cnt == SSW'(SECS_PER_MIN - 1));
  assign unit_tick = minutes ? min_tick : sec_tick;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      ms_cnt  <= '0;
      sec_cnt <= '0;
    end else if (tick_ms) begin
      ms_cnt <= sec_tick ? '0 : ms_cnt + 1'b1;
      if (sec_tick)
        sec_cnt <= min_tick ? '0 : sec_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wd_countdown.sv
module wd_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             unit_tick,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic step;

  assign step = run && unit_tick && (count != '0) && !load;
  assign fire = step && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count - 1'b1;
  end
endmodule

// File: rtl/wd_reset_out.sv
module wd_reset_out #(
  parameter int unsigned PW_CODE0_MS = 1,
  parameter int unsigned PW_CODE1_MS = 25,
  parameter int unsigned PW_CODE2_MS = 125,
  parameter int unsigned PW_CODE3_MS = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       fire,
  input  logic       pulse_mode,
  input  logic [1:0] width,
  input  logic       tick_ms,
  input  logic       gate,
  output logic       level_act,
  output logic       rst_n
);
  localparam int unsigned PW_MAX = wd_timer_pkg::max4(PW_CODE0_MS, PW_CODE1_MS,
                                                      PW_CODE2_MS, PW_CODE3_MS);
  localparam int PCW = $clog2(PW_MAX + 1);
  localparam int unsigned PW_TAB [4] = '{PW_CODE0_MS, PW_CODE1_MS, PW_CODE2_MS, PW_CODE3_MS};

  logic [PCW-1:0] pcnt;
  logic           active;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      level_act <= 1'b0;
      pcnt      <= '0;
    end else if (fire) begin
      if (pulse_mode) pcnt <= PCW'(PW_TAB[width]);
      else            level_act <= 1'b1;
    end else if (tick_ms && pcnt != '0) begin
      pcnt <= pcnt - 1'b1;
    end
  end

  assign active = level_act || (pcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) rst_n <= 1'b1;
    else     rst_n <= !(active && gate);
  end
endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SECS_PER_MIN  = 60,
  parameter int          CNT_W         = 8,
  parameter int unsigned PW_CODE0_MS   = 1,
  parameter int unsigned PW_CODE1_MS   = 25,
  parameter int unsigned PW_CODE2_MS   = 125,
  parameter int unsigned PW_CODE3_MS   = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_ms,
  output logic       wdt_rst_n
);
  import wd_timer_pkg::*;

  wd_cfg_t          cfg;
  logic [7:0]       out_reg;
  logic             cfg_wr;
  logic             cnt_wr;
  logic             out_wr;
  logic             unit_tick;
  logic             fire;
  logic             gate;
  logic             level_act;
  logic [CNT_W-1:0] count;

  assign cfg_wr = reg_wr && (reg_addr == ADDR_CFG);
  assign cnt_wr = reg_wr && (reg_addr == ADDR_CNT);
  assign out_wr = reg_wr && (reg_addr == ADDR_OUT);
  assign gate   = out_reg[OUT_OE_BIT] && out_reg[OUT_DEV_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      out_reg <= '0;
    end else begin
      if (cfg_wr) begin
        cfg.spare_hi <= reg_wdata[7];
        cfg.en       <= reg_wdata[CFG_EN_BIT];
        cfg.pulse    <= reg_wdata[CFG_PULSE_BIT];
        cfg.minutes  <= reg_wdata[CFG_MIN_BIT];
        cfg.spare_lo <= reg_wdata[2];
        cfg.width    <= reg_wdata[1:0];
      end
      if (fire)
        cfg.sts <= 1'b1;
      else if (cfg_wr && reg_wdata[CFG_STS_BIT])
        cfg.sts <= 1'b0;
      if (out_wr)
        out_reg <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_CFG: reg_rdata <= cfg;
        ADDR_CNT: reg_rdata <= 8'(count);
        ADDR_OUT: reg_rdata <= out_reg;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  wd_unit_tick #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SECS_PER_MIN (SECS_PER_MIN)
  ) i_unit (
    .clk      (clk),
    .rst      (rst),
    .run      (cfg.en),
    .restart  (cnt_wr),
    .tick_ms  (tick_ms),
    .minutes  (cfg.minutes),
    .unit_tick(unit_tick)
  );

  wd_countdown #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_wr),
    .load_val (CNT_W'(reg_wdata)),
    .run      (cfg.en),
    .unit_tick(unit_tick),
    .count    (count),
    .fire     (fire)
  );

  wd_reset_out #(
    .PW_CODE0_MS(PW_CODE0_MS),
    .PW_CODE1_MS(PW_CODE1_MS),
    .PW_CODE2_MS(PW_CODE2_MS),
    .PW_CODE3_MS(PW_CODE3_MS)
  ) i_out (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg.en),
    .fire      (fire),
    .pulse_mode(cfg.pulse),
    .width     (cfg.width),
    .tick_ms   (tick_ms),
    .gate      (gate),
    .level_act (level_act),
    .rst_n     (wdt_rst_n)
  );
endmodule

// File: rtl/wd_timer_chk.sv
module wd_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_wr,
  input logic             cfg_wr,
  input logic             sts_wbit,
  input logic             en,
  input logic             sts,
  input logic             unit_tick,
  input logic             level_act,
  input logic             gate,
  input logic [CNT_W-1:0] count,
  input logic             wdt_rst_n
);
  a_r10_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    !gate |=> wdt_rst_n);

  a_r5_zero_holds: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !cnt_wr) |=> count == '0);

  a_r6_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr) |=> $stable(count));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (en && unit_tick && count != '0 && !cnt_wr) |=> count == $past(count) - 1'b1);

  a_r9_sticky_status: assert property (@(posedge clk) disable iff (rst)
    (sts && !(cfg_wr && sts_wbit)) |=> sts);

  a_r7_level_held: assert property (@(posedge clk) disable iff (rst)
    (level_act && en) |=> level_act);
endmodule

bind wd_timer wd_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_wr   (cnt_wr),
  .cfg_wr   (cfg_wr),
  .sts_wbit (reg_wdata[6]),
  .en       (cfg.en),
  .sts      (cfg.sts),
  .unit_tick(unit_tick),
  .level_act(level_act),
  .gate     (gate),
  .count    (count),
  .wdt_rst_n(wdt_rst_n)
);

// File: tb/test_wd_timer.sv
module test_wd_timer;
  localparam int unsigned TPS = 4;
  localparam int unsigned SPM = 3;
  localparam int unsigned PW [4] = '{1, 2, 3, 6};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       tick_ms = 1'b1;
  logic       wdt_rst_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wd_timer #(
    .TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM), .CNT_W(8),
    .PW_CODE0_MS(1), .PW_CODE1_MS(2), .PW_CODE2_MS(3), .PW_CODE3_MS(6)
  ) i_wd_timer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_ms(tick_ms),
    .wdt_rst_n(wdt_rst_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic measure_low(output int k);
    k = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      k++;
      if (!wdt_rst_n) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rst_n after reset", wdt_rst_n, 1);
    rd(2'd0, d); check("R1 config reset", d, 0);
    rd(2'd1, d); check("R1 count reset", d, 0);
    rd(2'd2, d); check("R1 output ctl reset", d, 0);
  endtask

  task automatic t_seconds_level();
    int k;
    logic [7:0] d;
    wr(2'd2, 8'h81);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'd3);
    measure_low(k);
    check("R2 seconds delay", k, 3*TPS+1);
    rd(2'd0, d); check("R9 status set", d[6], 1);
    idle(20);
    check("R7 level held", wdt_rst_n, 0);
    wr(2'd0, 8'h00);
    idle(2);
    check("R7 released after disable", wdt_rst_n, 1);
    rd(2'd0, d); check("R9 write 0 keeps status", d[6], 1);
    wr(2'd0, 8'h40);
    rd(2'd0, d); check("R9 write 1 clears status", d[6], 0);
  endtask

  task automatic t_minutes();
    int k;
    wr(2'd0, 8'h28);
    wr(2'd1, 8'd2);
    measure_low(k);
    check("R3 minutes delay", k, 2*TPS*SPM+1);
    wr(2'd0, 8'h40);
    idle(2);
  endtask

  task automatic t_keepalive();
    int k;
    logic [7:0] d;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'd5);
    idle(5);
    rd(2'd1, d);
    check("R4 live count", d, 4);
    wr(2'd1, 8'd2);
    measure_low(k);
    check("R4 reload restarts delay", k, 2*TPS+1);
    wr(2'd0, 8'h40);
    idle(2);
  endtask

  task automatic t_pulse();
    for (int c = 0; c < 4; c++) begin
      int k;
      int len;
      logic [7:0] d;
      bit stayed;
      wr(2'd0, 8'(8'h30 | c));
      wr(2'd1, 8'd1);
      measure_low(k);
      check("R8 pulse start", k, TPS+1);
      len = 1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!wdt_rst_n) len++;
        else break;
      end
      check("R8 pulse width", len, int'(PW[c]));
      wr(2'd0, 8'(8'h70 | c));
      stayed = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!wdt_rst_n) stayed = 1'b0;
      end
      check("R5 one timeout per reload", stayed, 1);
      rd(2'd0, d); check("R5 no second status", d[6], 0);
      wr(2'd0, 8'h00);
    end
  endtask

  task automatic t_zero();
    logic [7:0] d;
    bit stayed;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'd0);
    stayed = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!wdt_rst_n) stayed = 1'b0;
    end
    check("R5 zero count never fires", stayed, 1);
    rd(2'd0, d); check("R5 zero count no status", d[6], 0);
    rd(2'd1, d); check("R5 zero count held", d, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_disable();
    int k;
    logic [7:0] d;
    bit stayed;
    wr(2'd0, 8'h20);
    wr(2'd1, 8'd2);
    idle(5);
    wr(2'd0, 8'h00);
    stayed = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!wdt_rst_n) stayed = 1'b0;
    end
    check("R6 disable fires nothing", stayed, 1);
    rd(2'd0, d); check("R6 no status when disabled", d[6], 0);
    rd(2'd1, d); check("R6 count frozen", d, 1);
    wr(2'd0, 8'h20);
    measure_low(k);
    check("R6 resume fresh unit", k, TPS+1);
    wr(2'd0, 8'h40);
    idle(2);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    bit stayed;
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'd1);
    stayed = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!wdt_rst_n) stayed = 1'b0;
    end
    check("R10 device bit off blocks output", stayed, 1);
    rd(2'd0, d); check("R10 status still set", d[6], 1);
    wr(2'd2, 8'h81);
    idle(1);
    check("R10 output follows gate on", wdt_rst_n, 0);
    wr(2'd2, 8'h01);
    idle(1);
    check("R10 enable bit off blocks output", wdt_rst_n, 1);
    wr(2'd0, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_seconds_level();
    t_minutes();
    t_keepalive();
    t_pulse();
    t_zero();
    t_disable();
    t_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule